// File: doc/BRIEF.md
# Color STN Panel Byte Interface

This block drives a single color passive-matrix panel over an 8-bit data bus. It runs from the pixel clock. From a set of timing values it builds the line pulse, the frame pulse, the AC-inversion toggle and the shift clock. It takes a stream of 1-bit red, green and blue pixels through a ready/valid handshake. Each run of eight pixels is 24 subpixels, and the block sends them to the panel as three bytes. Each byte is clocked by one rising edge of the shift clock. The three edges are unevenly spaced inside every eight-clock group.

Pixels are fetched one group ahead of the panel. The eight pixels taken during fetch group g reach the bus in the eight clocks that follow. The panel-side active window of a line is therefore the fetch window shifted by eight clocks, and the line pulse comes eight clocks after the fetch window closes. The timing values are taken in while reset is high and again at each frame boundary, so a change in the middle of a frame only takes effect at the next frame.

Top module: `stn8_color_if`

## Requirements
- R1: A line lasts (cfg_htotal+1)*8 clocks. Counting clocks from 0 at the start of each line, o_line is high for exactly one clock, at clock (cfg_hdisp+1)*8+8 of every line.
- R2: A frame lasts cfg_vtotal+1 lines, numbered from 0. o_frame is high only during the o_line pulse of line 0.
- R3: o_acinv is 0 after reset. It inverts on the first clock of line 0 of each new frame and at no other time.
- R4: pix_ready is high exactly on lines 0..cfg_vdisp, at clocks 0..(cfg_hdisp+1)*8-1 of those lines (the fetch window). It is low during reset.
- R5: On lines 0..cfg_vdisp, for clocks 8..(cfg_hdisp+1)*8+7 of the line (the output window), o_shift is high when (clock-8) mod 8 is 1, 4 or 7. It is low everywhere else.
- R6: The eight pixels fetched in one fetch group form a 24-subpixel sequence: pixel order, and within each pixel red (pix_rgb[2]), green (pix_rgb[1]), blue (pix_rgb[0]). In the next eight clocks this sequence goes out as byte 0 (output phases 0-2), byte 1 (phases 3-5) and byte 2 (phases 6-7). The earliest subpixel of each byte sits on o_data[7].
- R7: o_data holds the same value in the clock before each rising edge of o_shift as in the clock of that edge.
- R8: Accepted pixels fill a group's slots in order of acceptance. Slots still empty when the fetch group ends are sent as zero subpixels.
- R9: With the default BLANK_HOLD=0, o_data is zero outside the output window.
- R10: The four cfg_* inputs act only when captured during reset or on the last clock of a frame. A change at any other time takes effect from the next frame.
- R11: During reset all outputs (o_line, o_frame, o_acinv, o_shift, o_data, pix_ready) are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_htotal | input | HW | Line length in 8-clock units, minus one |
| cfg_hdisp | input | HW | Fetch window length in 8-pixel groups, minus one |
| cfg_vtotal | input | VW | Lines per frame, minus one |
| cfg_vdisp | input | VW | Active lines per frame, minus one |
| pix_valid | input | 1 | Pixel on pix_rgb is offered |
| pix_rgb | input | 3 | One pixel: red bit 2, green bit 1, blue bit 0 |
| pix_ready | output | 1 | Block accepts a pixel this clock |
| o_line | output | 1 | Line pulse to the panel |
| o_frame | output | 1 | Frame pulse to the panel |
| o_acinv | output | 1 | AC-drive inversion toggle |
| o_shift | output | 1 | Panel shift clock |
| o_data | output | 8 | Panel data byte |

## Verification
The hardest case to reach is a timing change made in the middle of a frame. It must leave the rest of that frame alone and then take hold exactly at the frame boundary. The stimulus changes the line length on the second line of the first frame. It then tracks every line pulse, frame pulse and inversion toggle through the end of the second frame against a model that switches line length only at the boundary. Partial groups are reached by withholding valid for the last three clocks of every fetch group, which produces a fixed, predictable byte pattern of zero fill.

// File: rtl/stn8_pkg.sv
package stn8_pkg;
   localparam int unsigned GRP_PIX     = 8;
   localparam int unsigned SUB_PER_PIX = 3;
   localparam int unsigned GRP_BITS    = GRP_PIX * SUB_PER_PIX;
   localparam int unsigned BUS_W       = 8;
   localparam int unsigned GRP_BYTES   = GRP_BITS / BUS_W;
   localparam int unsigned PH_W        = $clog2(GRP_PIX);

   typedef logic [GRP_BITS-1:0]    grp_t;
   typedef logic [SUB_PER_PIX-1:0] rgb_t;
   typedef logic [BUS_W-1:0]       byte_t;
   typedef logic [PH_W-1:0]        phase_t;

   typedef enum logic [1:0] {
      SLOT_B0 = 2'd0,
      SLOT_B1 = 2'd1,
      SLOT_B2 = 2'd2
   } slot_e;

   // byte carried on the bus during a given output phase
   function automatic slot_e slot_of(phase_t ph);
      if (ph < phase_t'(3))      return SLOT_B0;
      else if (ph < phase_t'(6)) return SLOT_B1;
      else                       return SLOT_B2;
   endfunction

   // phases in which the shift clock is high (3/3/2 spacing)
   function automatic logic edge_phase(phase_t ph);
      return (ph == phase_t'(1)) || (ph == phase_t'(4)) || (ph == phase_t'(7));
   endfunction
endpackage

// File: rtl/stn8_timing.sv
module stn8_timing #(
   parameter int unsigned HW = 7,
   parameter int unsigned VW = 10
) (
   input  logic          clk,
   input  logic          rst,
   input  logic [HW-1:0] cfg_htotal,
   input  logic [HW-1:0] cfg_hdisp,
   input  logic [VW-1:0] cfg_vtotal,
   input  logic [VW-1:0] cfg_vdisp,
   output logic [HW+2:0] hcnt,
   output logic [VW-1:0] vcnt,
   output logic          fetch_act,
   output logic          out_act,
   output logic          grp_last,
   output logic          line_pulse,
   output logic          frame_pulse,
   output logic          acinv
);
   localparam int unsigned HCW = HW + 3;
   localparam int unsigned CW  = HW + 5;

   logic [HW-1:0] ht_q, hdp_q;
   logic [VW-1:0] vt_q, vdp_q;
   logic [CW-1:0] hc_ext, fetch_end, out_end;
   logic          line_end, last_line, vis_line;

   assign hc_ext    = {2'b00, hcnt};
   assign fetch_end = {2'b00, hdp_q, 3'b000} + CW'(8);
   assign out_end   = fetch_end + CW'(8);
   assign line_end  = (hcnt == {ht_q, 3'b111});
   assign last_line = (vcnt == vt_q);
   assign vis_line  = (vcnt <= vdp_q);

   assign fetch_act   = vis_line && (hc_ext < fetch_end);
   assign out_act     = vis_line && (hc_ext >= CW'(8)) && (hc_ext < out_end);
   assign grp_last    = fetch_act && (hcnt[2:0] == 3'd7);
   assign line_pulse  = (hc_ext == out_end);
   assign frame_pulse = line_pulse && (vcnt == '0);

   always_ff @(posedge clk) begin
      if (rst) begin
         hcnt  <= '0;
         vcnt  <= '0;
         acinv <= 1'b0;
         ht_q  <= cfg_htotal;
         hdp_q <= cfg_hdisp;
         vt_q  <= cfg_vtotal;
         vdp_q <= cfg_vdisp;
      end else if (line_end) begin
         hcnt <= '0;
         if (last_line) begin
            vcnt  <= '0;
            acinv <= ~acinv;
            ht_q  <= cfg_htotal;
            hdp_q <= cfg_hdisp;
            vt_q  <= cfg_vtotal;
            vdp_q <= cfg_vdisp;
         end else begin
            vcnt <= vcnt + VW'(1);
         end
      end else begin
         hcnt <= hcnt + HCW'(1);
      end
   end
endmodule

// File: rtl/stn8_collect.sv
module stn8_collect
   import stn8_pkg::*;
(
   input  logic clk,
   input  logic rst,
   input  logic take,
   input  rgb_t rgb,
   input  logic grp_last,
   output grp_t grp_full
);
   localparam int unsigned CNTW = $clog2(GRP_PIX + 1);

   logic [CNTW-1:0] cnt;
   grp_t            acc;
   grp_t            merged;

   for (genvar i = 0; i < GRP_PIX; i++) begin : g_slot
      localparam int unsigned MSB = GRP_BITS - 1 - SUB_PER_PIX * i;
      logic hit;
      assign hit = take && (cnt == CNTW'(i));
      assign merged[MSB -: SUB_PER_PIX] = hit ? rgb : acc[MSB -: SUB_PER_PIX];
   end

   assign grp_full = merged;

   always_ff @(posedge clk) begin
      if (rst) begin
         acc <= '0;
         cnt <= '0;
      end else if (grp_last) begin
         acc <= '0;
         cnt <= '0;
      end else begin
         acc <= merged;
         if (take) cnt <= cnt + CNTW'(1);
      end
   end
endmodule

// File: rtl/stn8_serial.sv
module stn8_serial
   import stn8_pkg::*;
#(
   parameter bit BLANK_HOLD = 1'b0
) (
   input  logic   clk,
   input  logic   rst,
   input  logic   load,
   input  grp_t   grp_in,
   input  logic   out_act,
   input  phase_t phase,
   output logic   shift,
   output byte_t  data
);
   grp_t  out_q;
   byte_t cur;
   slot_e sel;

   assign sel   = slot_of(phase);
   assign cur   = out_q[(GRP_BYTES - 1 - int'(sel)) * BUS_W +: BUS_W];
   assign shift = out_act && edge_phase(phase);

   always_ff @(posedge clk) begin
      if (rst)       out_q <= '0;
      else if (load) out_q <= grp_in;
   end

   if (BLANK_HOLD) begin : g_hold
      byte_t hold_q;
      always_ff @(posedge clk) begin
         if (rst)          hold_q <= '0;
         else if (out_act) hold_q <= cur;
      end
      assign data = out_act ? cur : hold_q;
   end else begin : g_zero
      assign data = out_act ? cur : '0;
   end
endmodule

// File: rtl/stn8_color_if.sv
module stn8_color_if
   import stn8_pkg::*;
#(
   parameter int unsigned HW         = 7,
   parameter int unsigned VW         = 10,
   parameter bit          BLANK_HOLD = 1'b0
) (
   input  logic          clk,
   input  logic          rst,
   input  logic [HW-1:0] cfg_htotal,
   input  logic [HW-1:0] cfg_hdisp,
   input  logic [VW-1:0] cfg_vtotal,
   input  logic [VW-1:0] cfg_vdisp,
   input  logic          pix_valid,
   input  logic [2:0]    pix_rgb,
   output logic          pix_ready,
   output logic          o_line,
   output logic          o_frame,
   output logic          o_acinv,
   output logic          o_shift,
   output logic [7:0]    o_data
);
   if (HW < 2) begin : g_bad_hw
      $error("stn8_color_if: HW must be at least 2");
   end
   if (VW < 1) begin : g_bad_vw
      $error("stn8_color_if: VW must be at least 1");
   end
   if (GRP_BITS % BUS_W != 0) begin : g_bad_pack
      $error("stn8_color_if: group bits must fill whole bytes");
   end

   logic [HW+2:0] hcnt;
   logic [VW-1:0] vcnt;
   logic          fetch_act, out_act, grp_last, take;
   grp_t          grp_full;

   stn8_timing #(.HW(HW), .VW(VW)) u_timing (
      .clk        (clk),
      .rst        (rst),
      .cfg_htotal (cfg_htotal),
      .cfg_hdisp  (cfg_hdisp),
      .cfg_vtotal (cfg_vtotal),
      .cfg_vdisp  (cfg_vdisp),
      .hcnt       (hcnt),
      .vcnt       (vcnt),
      .fetch_act  (fetch_act),
      .out_act    (out_act),
      .grp_last   (grp_last),
      .line_pulse (o_line),
      .frame_pulse(o_frame),
      .acinv      (o_acinv)
   );

   assign pix_ready = fetch_act && !rst;
   assign take      = pix_ready && pix_valid;

   stn8_collect u_collect (
      .clk     (clk),
      .rst     (rst),
      .take    (take),
      .rgb     (pix_rgb),
      .grp_last(grp_last),
      .grp_full(grp_full)
   );

   stn8_serial #(.BLANK_HOLD(BLANK_HOLD)) u_serial (
      .clk    (clk),
      .rst    (rst),
      .load   (grp_last),
      .grp_in (grp_full),
      .out_act(out_act),
      .phase  (hcnt[2:0]),
      .shift  (o_shift),
      .data   (o_data)
   );
endmodule

// File: rtl/stn8_color_if_chk.sv
module stn8_color_if_chk #(
   parameter int unsigned HW         = 7,
   parameter int unsigned VW         = 10,
   parameter bit          BLANK_HOLD = 1'b0
) (
   input logic          clk,
   input logic          rst,
   input logic          o_line,
   input logic          o_frame,
   input logic          o_acinv,
   input logic          o_shift,
   input logic [7:0]    o_data,
   input logic          pix_ready,
   input logic          out_act,
   input logic [HW+2:0] hcnt,
   input logic [VW-1:0] vcnt
);
   // R1: line pulse lasts one clock
   p_line_one_clk_r1: assert property (@(posedge clk) disable iff (rst)
      o_line |=> !o_line);

   // R2: frame pulse only inside a line pulse
   p_frame_with_line_r2: assert property (@(posedge clk) disable iff (rst)
      o_frame |-> o_line);

   // R3: inversion flips only at the frame origin
   p_acinv_at_origin_r3: assert property (@(posedge clk) disable iff (rst)
      (o_acinv != $past(o_acinv)) |-> (hcnt == '0 && vcnt == '0));

   // R4: fetch window never overlaps the line pulse
   p_ready_not_line_r4: assert property (@(posedge clk) disable iff (rst)
      !(pix_ready && o_line));

   // R5: shift clock high one clock at a time, inside the output window
   p_shift_gap_r5: assert property (@(posedge clk) disable iff (rst)
      o_shift |=> !o_shift);
   p_shift_in_window_r5: assert property (@(posedge clk) disable iff (rst)
      o_shift |-> out_act);

   // R7: data settled before each rising shift edge
   p_data_stable_r7: assert property (@(posedge clk) disable iff (rst)
      $rose(o_shift) |-> $stable(o_data));

   // R9: blank bus outside the output window
   p_blank_zero_r9: assert property (@(posedge clk) disable iff (rst)
      (!BLANK_HOLD && !out_act) |-> (o_data == 8'h00));
endmodule

bind stn8_color_if stn8_color_if_chk #(.HW(HW), .VW(VW), .BLANK_HOLD(BLANK_HOLD)) u_chk (
   .clk      (clk),
   .rst      (rst),
   .o_line   (o_line),
   .o_frame  (o_frame),
   .o_acinv  (o_acinv),
   .o_shift  (o_shift),
   .o_data   (o_data),
   .pix_ready(pix_ready),
   .out_act  (out_act),
   .hcnt     (hcnt),
   .vcnt     (vcnt)
);

// File: tb/tb_stn8_color_if.sv
module tb_stn8_color_if;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [6:0] cfg_htotal = 7'd3;
   logic [6:0] cfg_hdisp  = 7'd1;
   logic [9:0] cfg_vtotal = 10'd3;
   logic [9:0] cfg_vdisp  = 10'd1;
   logic       pix_valid  = 1'b0;
   logic [2:0] pix_rgb    = 3'd0;
   logic       pix_ready, o_line, o_frame, o_acinv, o_shift;
   logic [7:0] o_data;

   int checks = 0;
   int fails  = 0;

   always #2 clk = ~clk;

   stn8_color_if dut (
      .clk(clk), .rst(rst),
      .cfg_htotal(cfg_htotal), .cfg_hdisp(cfg_hdisp),
      .cfg_vtotal(cfg_vtotal), .cfg_vdisp(cfg_vdisp),
      .pix_valid(pix_valid), .pix_rgb(pix_rgb), .pix_ready(pix_ready),
      .o_line(o_line), .o_frame(o_frame), .o_acinv(o_acinv),
      .o_shift(o_shift), .o_data(o_data)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s act=%0d exp=%0d", req, act, exp);
      end
   endtask

   // config A: line 32 clocks, fetch 16, 4 lines, 2 active
   task automatic start(input bit chk_reset);
      rst = 1'b1;
      pix_valid = 1'b0;
      cfg_htotal = 7'd3; cfg_hdisp = 7'd1; cfg_vtotal = 10'd3; cfg_vdisp = 10'd1;
      repeat (3) @(negedge clk);
      #1;
      if (chk_reset) begin
         check(o_line == 0,    "R11 line in reset",  int'(o_line), 0);
         check(o_frame == 0,   "R11 frame in reset", int'(o_frame), 0);
         check(o_acinv == 0,   "R11 acinv in reset", int'(o_acinv), 0);
         check(o_shift == 0,   "R11 shift in reset", int'(o_shift), 0);
         check(o_data == 0,    "R11 data in reset",  int'(o_data), 0);
         check(pix_ready == 0, "R11 ready in reset", int'(pix_ready), 0);
      end
      @(negedge clk);
      rst = 1'b0;
      #1;
   endtask

   function automatic logic [2:0] pval(input int n);
      return 3'((n * 5 + 3) & 7);
   endfunction

   function automatic logic [7:0] exp_byte(input int j);
      logic [7:0] b;
      for (int q = 0; q < 8; q++) begin
         int s = 8 * j + q;
         logic [2:0] v = pval(s / 3);
         b[7-q] = v[2 - (s % 3)];
      end
      return b;
   endfunction

   task automatic t_reset();
      start(1'b1);
   endtask

   // R1 R2 R4 R5 over two frames of config A
   task automatic t_timing();
      start(1'b0);
      pix_valid = 1'b1;
      for (int k = 0; k < 256; k++) begin
         int hc = k % 32;
         int vl = (k / 32) % 4;
         bit disp = (vl <= 1);
         bit e_line = (hc == 24);
         bit e_shift = disp && hc >= 8 && hc < 24 &&
                       ((hc % 8 == 1) || (hc % 8 == 4) || (hc % 8 == 7));
         check(o_line == e_line, "R1 line pulse", int'(o_line), int'(e_line));
         check(o_frame == (e_line && vl == 0), "R2 frame pulse", int'(o_frame), int'(e_line && vl == 0));
         check(pix_ready == (disp && hc < 16), "R4 ready window", int'(pix_ready), int'(disp && hc < 16));
         check(o_shift == e_shift, "R5 shift phase", int'(o_shift), int'(e_shift));
         @(negedge clk); #1;
      end
   endtask

   // R6 R7 R9 packing of a known stream over one frame
   task automatic t_pack();
      logic [7:0] got[12];
      int nb = 0, n = 0;
      bit took = 0, pshift = 0;
      logic [7:0] pdata = '0;
      start(1'b0);
      pix_valid = 1'b1;
      for (int k = 0; k < 128; k++) begin
         int hc = k % 32;
         int vl = k / 32;
         bit win = (vl <= 1) && hc >= 8 && hc < 24;
         if (o_shift && !pshift)
            check(o_data == pdata, "R7 data stable at shift", int'(o_data), int'(pdata));
         if (!win)
            check(o_data == 8'h00, "R9 blank data", int'(o_data), 0);
         if (o_shift) begin
            if (nb < 12) got[nb] = o_data;
            nb++;
         end
         pshift = o_shift;
         pdata  = o_data;
         if (took) n++;
         pix_rgb = pval(n);
         took = pix_ready && pix_valid;
         @(negedge clk); #1;
      end
      check(nb == 12, "R6 byte count", nb, 12);
      for (int j = 0; j < 12; j++)
         check(got[j] == exp_byte(j), "R6 packed byte", int'(got[j]), int'(exp_byte(j)));
   endtask

   // R8 valid only for the first five clocks of each fetch group
   task automatic t_underflow();
      logic [7:0] pat[3] = '{8'hFF, 8'hFE, 8'h00};
      int nb = 0;
      start(1'b0);
      pix_rgb = 3'b111;
      for (int k = 0; k < 128; k++) begin
         if (o_shift) begin
            check(o_data == pat[nb % 3], "R8 zero fill", int'(o_data), int'(pat[nb % 3]));
            nb++;
         end
         pix_valid = ((k + 1) % 8) < 5;
         @(negedge clk); #1;
      end
      check(nb == 12, "R8 byte count", nb, 12);
   endtask

   // R10 R3 mid-frame line length change applies from the next frame
   task automatic t_shadow();
      start(1'b0);
      for (int k = 0; k < 330; k++) begin
         bit e_line, e_frame, e_inv;
         if (k < 128) begin
            e_line = (k % 32 == 24); e_frame = (k == 24); e_inv = 0;
         end else if (k < 288) begin
            e_line = ((k - 128) % 40 == 24); e_frame = (k == 152); e_inv = 1;
         end else begin
            e_line = ((k - 288) % 40 == 24); e_frame = (k == 312); e_inv = 0;
         end
         check(o_line == e_line, "R10 line after cfg change", int'(o_line), int'(e_line));
         check(o_frame == e_frame, "R10 frame after cfg change", int'(o_frame), int'(e_frame));
         check(o_acinv == e_inv, "R3 acinv per frame", int'(o_acinv), int'(e_inv));
         if (k == 40) cfg_htotal = 7'd4;
         @(negedge clk); #1;
      end
   endtask

   initial begin
      t_reset();
      t_timing();
      t_pack();
      t_underflow();
      t_shadow();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      #800000;
      checks++;
      fails++;
      $display("FAIL watchdog expired act=%0d exp=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule